// File: doc/BRIEF.md
# Enhanced Parallel Port Peripheral Controller

This block sits on the peripheral side of a byte-wide enhanced parallel link to a host computer. The host starts each transfer by pulling one of two active-low strobes. One strobe marks an address transfer and the other marks a data transfer. A separate direction line from the host says whether the host writes or reads. The block decodes the strobe, answers with a WAIT handshake and drives the shared bus only while the host reads. The shared bus appears here as a separate input, output and output-enable. Address writes load an 8-bit command register, and address reads return that register.

Data reads stream 12-bit samples out of a local show-ahead FIFO. Each sample travels as two tagged bytes, upper half first. Bit 7 of each byte flags the half, bit 6 is zero and bits 5:0 carry six payload bits. The FIFO word is popped only after the lower-half byte has been handed over. Data writes are acknowledged and otherwise have no effect.

The state machine has five states. From IDLE it moves to ADDR_WR, ADDR_RD, DATA_WR or DATA_RD when a synchronised strobe is seen low. The address strobe has priority, and the direction line picks write or read. From each of those four states it returns to IDLE when its own synchronised strobe is seen high again. WAIT is high in every state except IDLE.

Top module: `epp_periph_port`

## Requirements
- R1: After reset, wait_o, bus_oe and fifo_pop are 0 and cmd_o is 0x00.
- R2: WAIT goes high on the third rising clock edge after a strobe falls. It goes low on the third rising edge after that strobe rises again. The strobes and the direction line pass through two flip-flops first.
- R3: An address strobe with nwrite low loads bus_in into cmd_o.
- R4: An address strobe with nwrite high drives cmd_o on bus_out, with bus_oe high, while WAIT is high.
- R5: The first data read of a FIFO word returns {1, 0, word[11:6]}, and no pop occurs.
- R6: The next data read returns {0, 0, word[5:0]}. Exactly one pop follows when the strobe is released, so the next data read returns the next word's upper half.
- R7: A data read while the FIFO is empty returns 0x00, pops nothing and does not advance the half sequence.
- R8: A data write changes neither cmd_o nor the half sequence, and it does not pop.
- R9: bus_oe is never high during a write cycle, and fifo_pop is high only after a lower-half byte.
- R10: An address cycle between the two halves of a word does not disturb the half sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nwrite | input | 1 | Host direction: 0 = host writes, 1 = host reads |
| nastb | input | 1 | Active-low address strobe |
| ndstb | input | 1 | Active-low data strobe |
| bus_in | input | 8 | Bus value driven by the host |
| bus_out | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | High when the block drives the bus |
| wait_o | output | 1 | Handshake reply to the host |
| cmd_o | output | 8 | Command/control register |
| fifo_rdata | input | 12 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Removes the head word |

## Verification
The assertions assume that the host follows the handshake. It never asserts both strobes at once. It holds nwrite and bus_in steady from before a strobe falls until WAIT drops. It never raises a strobe before it has seen WAIT high. They also assume that the FIFO head word stays fixed between pops. The bench host task sets the direction and bus value one clock before lowering a strobe. It waits for WAIT to rise before releasing the strobe and waits for WAIT to fall before starting the next cycle. The bench FIFO model changes its head word only on a pop or on a push into an empty queue.

// File: rtl/epp_port_pkg.sv
package epp_port_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_WR,
        ST_ADDR_RD,
        ST_DATA_WR,
        ST_DATA_RD
    } port_state_t;
endpackage

// File: rtl/epp_strobe_sync.sv
module epp_strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= '1;
            end else if (s == 0) begin
                pipe[s] <= async_in;
            end else begin
                pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/epp_half_seq.sv
module epp_half_seq #(
    parameter int SAMPLE_W = 12,
    parameter int BYTE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic                empty_i,
    input  logic                step_i,
    output logic [BYTE_W-1:0]   byte_o,
    output logic                pop_o
);
    localparam int HALF_W = SAMPLE_W / 2;
    localparam int PAD_W  = BYTE_W - 1 - HALF_W;

    logic is_lower;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_lower <= 1'b0;
        end else begin
            is_lower <= is_lower ^ step_i;
        end
    end

    always_comb begin
        if (empty_i) begin
            byte_o = '0;
        end else if (is_lower) begin
            byte_o = {1'b0, {PAD_W{1'b0}}, word_i[HALF_W-1:0]};
        end else begin
            byte_o = {1'b1, {PAD_W{1'b0}}, word_i[SAMPLE_W-1:HALF_W]};
        end
    end

    assign pop_o = step_i & is_lower;

    // R6: a pop must close a lower-half byte and is followed by an upper half
    a_r6_pop_resets_half: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !is_lower);
endmodule

// File: rtl/epp_periph_port.sv
module epp_periph_port
    import epp_port_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nwrite,
    input  logic                nastb,
    input  logic                ndstb,
    input  logic [BYTE_W-1:0]   bus_in,
    output logic [BYTE_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic                wait_o,
    output logic [BYTE_W-1:0]   cmd_o,
    input  logic [SAMPLE_W-1:0] fifo_rdata,
    input  logic                fifo_empty,
    output logic                fifo_pop
);
    localparam int CTRL_W = 3;

    port_state_t       state_q, state_d;
    logic [CTRL_W-1:0] ctrl_s;
    logic              nwr_s, nas_s, nds_s;
    logic [BYTE_W-1:0] cmd_q, rd_byte_q, half_byte;
    logic              rd_valid_q, step;

    epp_strobe_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({nwrite, nastb, ndstb}),
        .sync_out (ctrl_s)
    );
    assign {nwr_s, nas_s, nds_s} = ctrl_s;

    epp_half_seq #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (fifo_rdata),
        .empty_i (fifo_empty),
        .step_i  (step),
        .byte_o  (half_byte),
        .pop_o   (fifo_pop)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!nas_s)      state_d = nwr_s ? ST_ADDR_RD : ST_ADDR_WR;
                else if (!nds_s) state_d = nwr_s ? ST_DATA_RD : ST_DATA_WR;
            end
            ST_ADDR_WR, ST_ADDR_RD: if (nas_s) state_d = ST_IDLE;
            ST_DATA_WR, ST_DATA_RD: if (nds_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captures at the start of a cycle: command on address write, reply byte on reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            rd_byte_q  <= '0;
            rd_valid_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            unique case (state_d)
                ST_ADDR_WR: cmd_q <= bus_in;
                ST_ADDR_RD: rd_byte_q <= cmd_q;
                ST_DATA_RD: begin
                    rd_byte_q  <= half_byte;
                    rd_valid_q <= !fifo_empty;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wait_o  = (state_q != ST_IDLE);
        bus_oe  = (state_q == ST_ADDR_RD) || (state_q == ST_DATA_RD);
        bus_out = bus_oe ? rd_byte_q : '0;
        cmd_o   = cmd_q;
        step    = (state_q == ST_DATA_RD) && nds_s && rd_valid_q;
    end

    // R2: WAIT only rises once a synchronised strobe has been seen low
    a_r2_wait_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> ($past(!nas_s) || $past(!ndstb_sync_low_dummy)));

    // R3: the command register changes only when an address write begins
    a_r3_cmd_only_on_addr_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> (state_q == ST_ADDR_WR && $past(state_q) == ST_IDLE));

    // R9: the bus is driven only while the host reads
    a_r9_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (wait_o && nwr_s));

    // R7: nothing is popped while the FIFO is empty
    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    // R9: a pop happens only while a data read is being released
    a_r9_pop_in_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (state_q == ST_DATA_RD && nds_s));

    logic ndstb_sync_low_dummy;
    assign ndstb_sync_low_dummy = nds_s;
endmodule

// File: tb/epp_periph_port_test.sv
module epp_periph_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nwrite = 1'b1, nastb = 1'b1, ndstb = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out, cmd_o;
    logic        bus_oe, wait_o, fifo_pop;
    logic [11:0] fifo_rdata;
    logic        fifo_empty;

    logic [11:0] mem [0:63];
    int wr_ptr = 0;
    int rd_ptr = 0;
    int pops   = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_rdata = mem[rd_ptr[5:0]];

    always @(posedge clk) begin
        if (fifo_pop) begin
            rd_ptr <= rd_ptr + 1;
            pops   <= pops + 1;
        end
    end

    epp_periph_port uut (
        .clk(clk), .rst_n(rst_n), .nwrite(nwrite), .nastb(nastb), .ndstb(ndstb),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wait_o(wait_o),
        .cmd_o(cmd_o), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // One host cycle; returns the byte seen while WAIT is high and edge counts
    task automatic host_cycle(input bit is_addr, input bit is_write, input logic [7:0] din,
                              output logic [7:0] dout, output bit oe,
                              output int rise_n, output int fall_n);
        @(negedge clk);
        nwrite = !is_write;
        bus_in = din;
        @(negedge clk);
        if (is_addr) nastb = 1'b0; else ndstb = 1'b0;
        rise_n = 0;
        while (!wait_o && rise_n < 20) begin
            @(posedge clk); rise_n++;
            @(negedge clk);
        end
        dout = bus_out;
        oe   = bus_oe;
        nastb = 1'b1;
        ndstb = 1'b1;
        fall_n = 0;
        while (wait_o && fall_n < 20) begin
            @(posedge clk); fall_n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        bit oe;
        int rn, fn, p0;
        for (int i = 0; i < 64; i++) mem[i] = 12'((i * 173 + 5) & 12'hFFF);
        mem[1] = 12'hFFF;
        mem[2] = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 wait", wait_o, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 pop", fifo_pop, 0);
        chk("R1 cmd", cmd_o, 0);
        rst_n = 1'b1;

        // R3/R4/R2/R9: every command value written then read back
        for (int v = 0; v < 256; v++) begin
            host_cycle(1, 1, 8'(v), d, oe, rn, fn);
            chk("R3 cmd load", cmd_o, v);
            chk("R9 no oe on write", oe, 0);
            if (v == 0) begin
                chk("R2 rise edges", rn, 3);
                chk("R2 fall edges", fn, 3);
            end
            host_cycle(1, 0, 8'h00, d, oe, rn, fn);
            chk("R4 cmd read", d, v);
            chk("R4 oe", oe, 1);
        end

        // R8: data write is acknowledged only
        host_cycle(1, 1, 8'hA5, d, oe, rn, fn);
        host_cycle(0, 1, 8'h3C, d, oe, rn, fn);
        chk("R8 cmd kept", cmd_o, 8'hA5);
        chk("R8 no pop", pops, 0);
        chk("R8 no oe", oe, 0);
        chk("R2 data rise edges", rn, 3);

        // R7: empty read
        host_cycle(0, 0, 8'h00, d, oe, rn, fn);
        chk("R7 empty byte", d, 0);
        chk("R7 empty no pop", pops, 0);

        wr_ptr = 40;
        for (int w = 0; w < 40; w++) begin
            logic [11:0] word;
            word = mem[w];
            p0 = pops;
            host_cycle(0, 0, 8'h00, d, oe, rn, fn);
            chk("R5 upper byte", d, {1'b1, 1'b0, word[11:6]});
            chk("R5 no pop", pops, p0);
            if (w == 3) begin
                host_cycle(1, 0, 8'h00, d, oe, rn, fn);
                chk("R10 cmd read mid word", d, 8'hA5);
                host_cycle(1, 1, 8'h5A, d, oe, rn, fn);
                host_cycle(1, 1, 8'hA5, d, oe, rn, fn);
            end
            if (w == 5) host_cycle(0, 1, 8'hFF, d, oe, rn, fn);
            host_cycle(0, 0, 8'h00, d, oe, rn, fn);
            chk(w == 3 ? "R10 lower after addr" : (w == 5 ? "R8 lower after dwr" : "R6 lower byte"),
                d, {2'b00, word[5:0]});
            chk("R6 one pop", pops, p0 + 1);
        end

        // R7: empty again, then the sequence resumes with an upper half
        host_cycle(0, 0, 8'h00, d, oe, rn, fn);
        chk("R7 empty byte again", d, 0);
        chk("R7 no pop again", pops, 40);
        wr_ptr = 41;
        host_cycle(0, 0, 8'h00, d, oe, rn, fn);
        chk("R7 upper after empty", d, {1'b1, 1'b0, mem[40][11:6]});
        host_cycle(0, 0, 8'h00, d, oe, rn, fn);
        chk("R7 lower after empty", d, {2'b00, mem[40][5:0]});
        chk("R6 final pops", pops, 41);
        finish_run();
    end
endmodule